// File: doc/BRIEF.md
# Ping-Pong Frame Line Buffer Swap Arbiter

This block sits between a line writer, a line reader and two SDRAM devices used as a ping-pong pair. At any moment one device belongs to the writer and the other to the reader. The writer's command, address and write data go to its device. The reader's command and address go to the other device. Read data coming back from the reader's device is selected and passed on toward a downstream FIFO as a valid/ready stream.

The arbiter decides when the two devices change roles. A role exchange is allowed only while the camera is idle between lines. The reader must also report that its device is drained, and the writer must have completed at least one line in its device. If the reader keeps pace with the camera, the roles change after every line and each device holds one line. If the reader falls behind, the writer keeps appending lines at rising row numbers in the same device. At each exchange the reader is told how many lines the device it takes over holds. A sticky flag reports when the camera starts a new line while every row of the writer's device is already used.

The read stream has no storage of its own. `out_valid` follows `rd_beat_valid` and `rd_beat_ready` follows `out_ready`. The reader must hold each beat on its device's read data until a cycle in which both valid and ready are high.

Top module: `pingpong_swap_arbiter`

## Requirements
- R1: While `rst_n` is low, `sel` is 0, `wr_row` is 0, `rd_lines` is 0, `rd_lines_load` is 0 and `overflow` is 0.
- R2: With `sel`=0, device A receives `wr_cmd`, `wr_addr` and `wr_data`, and device B receives `rd_cmd` and `rd_addr` with write data 0. With `sel`=1 the two devices are exchanged. The routing is combinational.
- R3: `out_data` is the read data of the device on the reader side: B when `sel`=0, A when `sel`=1. `out_valid` equals `rd_beat_valid` and `rd_beat_ready` equals `out_ready` in the same cycle.
- R4: Each `line_done` pulse that does not cause a swap raises `wr_row` by one after the clock edge. The count saturates at NUM_ROWS.
- R5: A swap window opens on a `line_done` pulse. It stays open while `cam_idle` is high and closes when `cam_idle` is low or a swap happens. A swap happens on an edge where the window is open (including the `line_done` cycle itself), `cam_idle` and `rd_drained` are both high, and the line count is nonzero. After that edge, `sel` is inverted.
- R6: On a swap, `rd_lines` takes the line count of the device being handed over, including a line completed in that same cycle. `rd_lines_load` is high for exactly one cycle, and `wr_row` returns to 0.
- R7: No swap happens in a cycle with `cam_idle` low, even when `line_done` and `rd_drained` are both high. The writer keeps its device and its row advances.
- R8: If the reader is not drained at `line_done`, but `rd_drained` rises later in the same idle gap, the swap happens on that later edge.
- R9: Once the camera resumes (`cam_idle` low), a later idle cycle with `rd_drained` high and no new `line_done` causes no swap.
- R10: `overflow` is set on the edge where `cam_idle` goes from 1 to 0 while `wr_row` equals NUM_ROWS. Once set it stays 1 until reset. A camera restart with a free row leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_idle | input | 1 | Camera is in its gap between lines |
| line_done | input | 1 | One-cycle pulse: writer finished a line |
| rd_drained | input | 1 | Reader has emptied its device |
| wr_cmd | input | CMD_W | Writer command lines |
| wr_addr | input | ADDR_W | Writer address |
| wr_data | input | DATA_W | Writer data |
| rd_cmd | input | CMD_W | Reader command lines |
| rd_addr | input | ADDR_W | Reader address |
| dev_a_cmd | output | CMD_W | Command to device A |
| dev_a_addr | output | ADDR_W | Address to device A |
| dev_a_wdata | output | DATA_W | Write data to device A |
| dev_a_rdata | input | DATA_W | Read data from device A |
| dev_b_cmd | output | CMD_W | Command to device B |
| dev_b_addr | output | ADDR_W | Address to device B |
| dev_b_wdata | output | DATA_W | Write data to device B |
| dev_b_rdata | input | DATA_W | Read data from device B |
| rd_beat_valid | input | 1 | Reader marks the current read beat valid |
| rd_beat_ready | output | 1 | Downstream accepts the beat (copy of out_ready) |
| out_valid | output | 1 | Stream valid toward the FIFO |
| out_ready | input | 1 | Stream ready from the FIFO |
| out_data | output | DATA_W | Selected read data |
| sel | output | 1 | Role select: 0 means A is written and B is read |
| wr_row | output | $clog2(NUM_ROWS+1) | Lines written so far into the writer's device |
| rd_lines | output | $clog2(NUM_ROWS+1) | Lines valid in the reader's device |
| rd_lines_load | output | 1 | One-cycle pulse when rd_lines is updated at a swap |
| overflow | output | 1 | Sticky: camera restarted with the writer's device full |

## Verification
A role register that flips at the wrong time shows at once on the device ports: on the very next cycle, writer commands appear on the device being read, and `out_data` switches to the wrong device. A bad swap window or bad drained gating shows as a `sel` change on the wrong edge. It can be seen one cycle after the cycle that caused it, and `rd_lines_load` and `wr_row` change with it. A wrong line count shows only later, when it is handed over as `rd_lines` at the next swap, or as `overflow` when the camera next restarts.

// File: rtl/ppsw_pkg.sv
package ppsw_pkg;
  typedef enum logic {
    ROLE_A_WRITES = 1'b0,
    ROLE_B_WRITES = 1'b1
  } role_e;
endpackage

// File: rtl/ppsw_swap_ctrl.sv
module ppsw_swap_ctrl
  import ppsw_pkg::*;
#(
  parameter int NUM_ROWS = 4096,
  parameter int CNT_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cam_idle,
  input  logic             line_done,
  input  logic             rd_drained,
  output role_e            role,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] lines_out,
  output logic             lines_load,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ROWS_C = CNT_W'(NUM_ROWS);

  role_e            role_q;
  logic [CNT_W-1:0] fill_q, fill_inc, lines_q;
  logic             win_q, win, swap, full, load_q, idle_q, ovf_q;

  assign full     = (fill_q == ROWS_C);
  assign fill_inc = (line_done && !full) ? fill_q + 1'b1 : fill_q;
  assign win      = line_done | win_q;
  assign swap     = cam_idle & rd_drained & win & (fill_inc != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q  <= ROLE_A_WRITES;
      fill_q  <= '0;
      lines_q <= '0;
      load_q  <= 1'b0;
      win_q   <= 1'b0;
      idle_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (swap) begin
        role_q  <= (role_q == ROLE_A_WRITES) ? ROLE_B_WRITES : ROLE_A_WRITES;
        lines_q <= fill_inc;
        fill_q  <= '0;
      end else begin
        fill_q  <= fill_inc;
      end
      load_q <= swap;
      win_q  <= win & cam_idle & ~swap;
      idle_q <= cam_idle;
      ovf_q  <= ovf_q | (idle_q & ~cam_idle & full);
    end
  end

  assign role       = role_q;
  assign fill       = fill_q;
  assign lines_out  = lines_q;
  assign lines_load = load_q;
  assign ovf        = ovf_q;
endmodule

// File: rtl/ppsw_dev_router.sv
module ppsw_dev_router
  import ppsw_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  role_e                        role,
  input  logic [CMD_W-1:0]             wr_cmd,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [CMD_W-1:0]             rd_cmd,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [1:0][CMD_W-1:0]        dev_cmd,
  output logic [1:0][ADDR_W-1:0]       dev_addr,
  output logic [1:0][DATA_W-1:0]       dev_wdata
);
  for (genvar g = 0; g < 2; g++) begin : g_dev
    localparam role_e OWN_ROLE = (g == 0) ? ROLE_A_WRITES : ROLE_B_WRITES;
    logic is_wr;
    assign is_wr        = (role == OWN_ROLE);
    assign dev_cmd[g]   = is_wr ? wr_cmd  : rd_cmd;
    assign dev_addr[g]  = is_wr ? wr_addr : rd_addr;
    assign dev_wdata[g] = is_wr ? wr_data : '0;
  end
endmodule

// File: rtl/ppsw_rdata_mux.sv
module ppsw_rdata_mux
  import ppsw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  role_e                  role,
  input  logic [1:0][DATA_W-1:0] dev_rdata,
  input  logic                   beat_valid,
  output logic                   beat_ready,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data
);
  assign out_data   = (role == ROLE_A_WRITES) ? dev_rdata[1] : dev_rdata[0];
  assign out_valid  = beat_valid;
  assign beat_ready = out_ready;
endmodule

// File: rtl/pingpong_swap_arbiter.sv
module pingpong_swap_arbiter
  import ppsw_pkg::*;
#(
  parameter int CMD_W    = 4,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 16,
  parameter int NUM_ROWS = 4096,
  localparam int CNT_W   = $clog2(NUM_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_idle,
  input  logic              line_done,
  input  logic              rd_drained,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CMD_W-1:0]  rd_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CMD_W-1:0]  dev_a_cmd,
  output logic [ADDR_W-1:0] dev_a_addr,
  output logic [DATA_W-1:0] dev_a_wdata,
  input  logic [DATA_W-1:0] dev_a_rdata,
  output logic [CMD_W-1:0]  dev_b_cmd,
  output logic [ADDR_W-1:0] dev_b_addr,
  output logic [DATA_W-1:0] dev_b_wdata,
  input  logic [DATA_W-1:0] dev_b_rdata,
  input  logic              rd_beat_valid,
  output logic              rd_beat_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              sel,
  output logic [CNT_W-1:0]  wr_row,
  output logic [CNT_W-1:0]  rd_lines,
  output logic              rd_lines_load,
  output logic              overflow
);
  role_e                  role;
  logic [1:0][CMD_W-1:0]  dcmd;
  logic [1:0][ADDR_W-1:0] daddr;
  logic [1:0][DATA_W-1:0] dwdata;
  logic [1:0][DATA_W-1:0] drdata;

  ppsw_swap_ctrl #(.NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cam_idle(cam_idle), .line_done(line_done),
    .rd_drained(rd_drained), .role(role), .fill(wr_row), .lines_out(rd_lines),
    .lines_load(rd_lines_load), .ovf(overflow)
  );

  ppsw_dev_router #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .role(role), .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_cmd(rd_cmd), .rd_addr(rd_addr), .dev_cmd(dcmd), .dev_addr(daddr),
    .dev_wdata(dwdata)
  );

  assign drdata = {dev_b_rdata, dev_a_rdata};

  ppsw_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .role(role), .dev_rdata(drdata), .beat_valid(rd_beat_valid),
    .beat_ready(rd_beat_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  assign dev_a_cmd   = dcmd[0];
  assign dev_a_addr  = daddr[0];
  assign dev_a_wdata = dwdata[0];
  assign dev_b_cmd   = dcmd[1];
  assign dev_b_addr  = daddr[1];
  assign dev_b_wdata = dwdata[1];
  assign sel         = (role == ROLE_B_WRITES);
endmodule

// File: rtl/ppsw_checker.sv
module ppsw_checker #(
  parameter int CMD_W    = 4,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 16,
  parameter int NUM_ROWS = 4096,
  parameter int CNT_W    = $clog2(NUM_ROWS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cam_idle,
  input logic              rd_drained,
  input logic [CMD_W-1:0]  wr_cmd,
  input logic [DATA_W-1:0] wr_data,
  input logic [CMD_W-1:0]  rd_cmd,
  input logic [CMD_W-1:0]  dev_a_cmd,
  input logic [DATA_W-1:0] dev_a_wdata,
  input logic [DATA_W-1:0] dev_a_rdata,
  input logic [CMD_W-1:0]  dev_b_cmd,
  input logic [DATA_W-1:0] dev_b_wdata,
  input logic [DATA_W-1:0] dev_b_rdata,
  input logic [DATA_W-1:0] out_data,
  input logic              sel,
  input logic [CNT_W-1:0]  wr_row,
  input logic [CNT_W-1:0]  rd_lines,
  input logic              rd_lines_load,
  input logic              overflow
);
  localparam logic [CNT_W-1:0] ROWS_C = CNT_W'(NUM_ROWS);

  a_r2_route_a_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (dev_a_cmd == wr_cmd && dev_a_wdata == wr_data && dev_b_cmd == rd_cmd && dev_b_wdata == '0));
  a_r2_route_b_writes: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (dev_b_cmd == wr_cmd && dev_b_wdata == wr_data && dev_a_cmd == rd_cmd && dev_a_wdata == '0));
  a_r3_read_side: assert property (@(posedge clk) disable iff (!rst_n)
    out_data == (sel ? dev_a_rdata : dev_b_rdata));
  a_r4_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_row <= ROWS_C);
  a_r5_swap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(cam_idle && rd_drained));
  a_r6_swap_effects: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> (rd_lines_load && wr_row == '0 && rd_lines != '0));
  a_r6_load_only_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lines_load |-> (sel != $past(sel)));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);
endmodule

bind pingpong_swap_arbiter ppsw_checker #(
  .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cam_idle(cam_idle), .rd_drained(rd_drained),
  .wr_cmd(wr_cmd), .wr_data(wr_data), .rd_cmd(rd_cmd),
  .dev_a_cmd(dev_a_cmd), .dev_a_wdata(dev_a_wdata), .dev_a_rdata(dev_a_rdata),
  .dev_b_cmd(dev_b_cmd), .dev_b_wdata(dev_b_wdata), .dev_b_rdata(dev_b_rdata),
  .out_data(out_data), .sel(sel), .wr_row(wr_row), .rd_lines(rd_lines),
  .rd_lines_load(rd_lines_load), .overflow(overflow)
);

// File: tb/pingpong_swap_arbiter_bench.sv
module pingpong_swap_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_W = 4, ADDR_W = 13, DATA_W = 16, NUM_ROWS = 4;
  localparam int CNT_W = $clog2(NUM_ROWS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cam_idle = 1'b0, line_done = 1'b0, rd_drained = 1'b0;
  logic [CMD_W-1:0]  wr_cmd = '0, rd_cmd = '0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, dev_a_rdata = '0, dev_b_rdata = '0;
  logic rd_beat_valid = 1'b0, out_ready = 1'b0;
  logic [CMD_W-1:0]  dev_a_cmd, dev_b_cmd;
  logic [ADDR_W-1:0] dev_a_addr, dev_b_addr;
  logic [DATA_W-1:0] dev_a_wdata, dev_b_wdata, out_data;
  logic rd_beat_ready, out_valid, sel, rd_lines_load, overflow;
  logic [CNT_W-1:0] wr_row, rd_lines;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_swap_arbiter #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS))
  u_pingpong_swap_arbiter (
    .clk(clk), .rst_n(rst_n), .cam_idle(cam_idle), .line_done(line_done), .rd_drained(rd_drained),
    .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data), .rd_cmd(rd_cmd), .rd_addr(rd_addr),
    .dev_a_cmd(dev_a_cmd), .dev_a_addr(dev_a_addr), .dev_a_wdata(dev_a_wdata), .dev_a_rdata(dev_a_rdata),
    .dev_b_cmd(dev_b_cmd), .dev_b_addr(dev_b_addr), .dev_b_wdata(dev_b_wdata), .dev_b_rdata(dev_b_rdata),
    .rd_beat_valid(rd_beat_valid), .rd_beat_ready(rd_beat_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .sel(sel), .wr_row(wr_row), .rd_lines(rd_lines),
    .rd_lines_load(rd_lines_load), .overflow(overflow)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per cycle: {cam_idle, line_done, rd_drained, exp_sel, exp_load, exp_row[3:0], exp_lines[3:0]}
  localparam logic [12:0] VEC [12] = '{
    13'b000_00_0000_0000,  // idle camera busy
    13'b011_00_0001_0000,  // R7: line done while camera busy, no swap
    13'b101_00_0001_0000,  // R9: no window left, no swap
    13'b110_00_0010_0000,  // R8: line done, reader not drained
    13'b101_11_0000_0010,  // R8 R6: drained later in same gap, swap with 2 lines
    13'b101_10_0000_0010,  // R5: window closed after swap
    13'b000_10_0000_0010,
    13'b111_01_0000_0001,  // R5 R6: keep-pace swap on the line_done cycle
    13'b000_00_0000_0001,
    13'b110_00_0001_0001,  // R4: line counted, window open
    13'b001_00_0001_0001,  // R7 R9: camera resumed, window closes
    13'b101_00_0001_0001   // R9: drained later, no swap
  };

  task automatic step(logic idle, logic ld, logic dr);
    @(negedge clk);
    cam_idle = idle; line_done = ld; rd_drained = dr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 sel", sel, 0);
    chk("R1 wr_row", int'(wr_row), 0);
    chk("R1 rd_lines", int'(rd_lines), 0);
    chk("R1 rd_lines_load", rd_lines_load, 0);
    chk("R1 overflow", overflow, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10]);
      chk("R5 R7 R8 R9 vector sel", sel, int'(VEC[i][9]));
      chk("R6 vector rd_lines_load", rd_lines_load, int'(VEC[i][8]));
      chk("R4 R6 vector wr_row", int'(wr_row), int'(VEC[i][7:4]));
      chk("R6 vector rd_lines", int'(rd_lines), int'(VEC[i][3:0]));
      chk("R10 vector overflow stays clear", overflow, 0);
    end

    // R4 fill to the top and saturate
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    chk("R4 row full", int'(wr_row), NUM_ROWS);
    step(1, 1, 0);
    chk("R4 row saturates", int'(wr_row), NUM_ROWS);
    chk("R4 no swap while not drained", sel, 0);
    // R10 camera restarts with no free row
    step(0, 0, 0);
    chk("R10 overflow set", overflow, 1);
    step(0, 0, 1);
    chk("R10 overflow sticky", overflow, 1);
    chk("R7 no swap while camera busy", sel, 0);
    step(1, 1, 1);
    chk("R6 swap from full device sel", sel, 1);
    chk("R6 handed over line count", int'(rd_lines), NUM_ROWS);
    chk("R6 row reset", int'(wr_row), 0);
    chk("R10 overflow sticky across swap", overflow, 1);

    // R2 R3 routing with sel=1
    @(negedge clk);
    cam_idle = 0; line_done = 0; rd_drained = 0;
    wr_cmd = 4'h5; wr_addr = 13'h0AA; wr_data = 16'h1234;
    rd_cmd = 4'hA; rd_addr = 13'h155;
    dev_a_rdata = 16'hAAAA; dev_b_rdata = 16'hBBBB;
    rd_beat_valid = 1'b1; out_ready = 1'b0;
    #1;
    chk("R2 sel1 dev_b_cmd", int'(dev_b_cmd), 5);
    chk("R2 sel1 dev_b_addr", int'(dev_b_addr), 'h0AA);
    chk("R2 sel1 dev_b_wdata", int'(dev_b_wdata), 'h1234);
    chk("R2 sel1 dev_a_cmd", int'(dev_a_cmd), 'hA);
    chk("R2 sel1 dev_a_addr", int'(dev_a_addr), 'h155);
    chk("R2 sel1 dev_a_wdata", int'(dev_a_wdata), 0);
    chk("R3 sel1 out_data", int'(out_data), 'hAAAA);
    chk("R3 out_valid", out_valid, 1);
    chk("R3 rd_beat_ready low", rd_beat_ready, 0);
    out_ready = 1'b1; rd_beat_valid = 1'b0;
    #1;
    chk("R3 rd_beat_ready high", rd_beat_ready, 1);
    chk("R3 out_valid low", out_valid, 0);

    // R1 reset again clears everything
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 re-reset sel", sel, 0);
    chk("R1 re-reset overflow", overflow, 0);
    chk("R1 re-reset rd_lines", int'(rd_lines), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 sel0 dev_a_cmd", int'(dev_a_cmd), 5);
    chk("R2 sel0 dev_a_wdata", int'(dev_a_wdata), 'h1234);
    chk("R2 sel0 dev_b_cmd", int'(dev_b_cmd), 'hA);
    chk("R2 sel0 dev_b_wdata", int'(dev_b_wdata), 0);
    chk("R3 sel0 out_data", int'(out_data), 'hBBBB);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule